// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block picks the address of the next instruction for a 32-bit RISC core in a single combinational pass. It takes the current program counter, the decoded primary opcode and function code, the 16-bit immediate, the 26-bit jump index and the two register operand values. From these it produces the next program counter for four cases: sequential flow, conditional branches, absolute jumps and register-indirect jumps. The call forms also raise a link-write strobe. That strobe carries the return address and the number of the link register.

The fetch stage registers `next_pc_o` as its new program counter. The register file takes `link_we_o`, `link_addr_o` and `link_val_o` as an extra write port. `redirect_o` tells the fetch stage that the flow has left the sequential path. Delay slots, exceptions and instruction fetch belong to other blocks.

Top module: `npc_unit`

## Requirements
- R1: An instruction that is not a branch, jump or register jump yields `next_pc_o` = PC+4 (modulo 2^32), `redirect_o` = 0 and `link_we_o` = 0.
- R2: Opcode 000100 is taken when the two register operands are equal. Opcode 000101 is taken when they differ. A branch that is not taken yields PC+4.
- R3: Opcode 000110 is taken when the first operand, read as a signed 32-bit value, is less than or equal to zero. Opcode 000111 is taken when it is greater than zero.
- R4: The target of a taken branch is PC+4 plus the immediate, sign-extended from bit 15 and shifted left by 2. The sum wraps modulo 2^32.
- R5: Opcodes 000010 and 000011 jump to bits 31:28 of the current PC, followed by the 26-bit index, followed by two zero bits.
- R6: Opcode 000000 with function 001000 or 001001 sets `next_pc_o` to the first register operand.
- R7: `link_we_o` is 1 only for opcode 000011 and for opcode 000000 with function 001001. `link_addr_o` is always 31. `link_val_o` is always PC+4.
- R8: `redirect_o` is 1 for every taken branch, every jump and every register jump, even when the target equals PC+4. It is 0 otherwise.
- R9: The function code has no effect when the opcode is not 000000. The second operand has no effect on opcodes 000110 and 000111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Primary opcode field |
| funct_i | input | 6 | Function field, used when the opcode is 000000 |
| imm_i | input | 16 | Branch displacement in words |
| jidx_i | input | 26 | Jump index field |
| rs_val_i | input | 32 | First register operand value |
| rt_val_i | input | 32 | Second register operand value |
| next_pc_o | output | 32 | Address of the next instruction |
| redirect_o | output | 1 | High when the flow leaves the sequential path |
| link_we_o | output | 1 | Write enable for the return address |
| link_addr_o | output | 5 | Register number that receives the return address |
| link_val_o | output | 32 | Return address |

## Verification
The call forms make the unit do two jobs in one evaluation: redirect the program counter and write a return address. For these the bench checks both the target and the link outputs from the same input vector. A register call whose operand equals PC+4 is also driven. In that case `next_pc_o` matches the sequential value, yet `redirect_o` and `link_we_o` must still both read 1. Taken branches are driven as well, including a zero displacement, a wrap past the top of the address space and the most negative immediate. These show that redirection and the link strobe are separate outputs, because a branch must never write the link register.

// File: rtl/npc_pkg.sv
package npc_pkg;

   localparam int OP_W = 6;
   localparam int FN_W = 6;

   localparam logic [OP_W-1:0] OPC_SPECIAL = 6'b000000;
   localparam logic [OP_W-1:0] OPC_J       = 6'b000010;
   localparam logic [OP_W-1:0] OPC_JAL     = 6'b000011;
   localparam logic [OP_W-1:0] OPC_BEQ     = 6'b000100;
   localparam logic [OP_W-1:0] OPC_BNE     = 6'b000101;
   localparam logic [OP_W-1:0] OPC_BLEZ    = 6'b000110;
   localparam logic [OP_W-1:0] OPC_BGTZ    = 6'b000111;

   localparam logic [FN_W-1:0] FN_JR       = 6'b001000;
   localparam logic [FN_W-1:0] FN_JALR     = 6'b001001;

   typedef enum logic [3:0] {
      FLOW_SEQ,
      FLOW_BR_EQ,
      FLOW_BR_NE,
      FLOW_BR_LEZ,
      FLOW_BR_GTZ,
      FLOW_JUMP,
      FLOW_CALL,
      FLOW_RJUMP,
      FLOW_RCALL
   } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [OP_W-1:0] opcode_i,
   input  logic [FN_W-1:0] funct_i,
   output flow_e           flow_o,
   output logic            is_cond_o,
   output logic            is_link_o
);

   always_comb begin
      flow_o = FLOW_SEQ;
      unique case (opcode_i)
         OPC_BEQ  : flow_o = FLOW_BR_EQ;
         OPC_BNE  : flow_o = FLOW_BR_NE;
         OPC_BLEZ : flow_o = FLOW_BR_LEZ;
         OPC_BGTZ : flow_o = FLOW_BR_GTZ;
         OPC_J    : flow_o = FLOW_JUMP;
         OPC_JAL  : flow_o = FLOW_CALL;
         OPC_SPECIAL : begin
            if (funct_i == FN_JR)        flow_o = FLOW_RJUMP;
            else if (funct_i == FN_JALR) flow_o = FLOW_RCALL;
            else                         flow_o = FLOW_SEQ;
         end
         default  : flow_o = FLOW_SEQ;
      endcase
   end

   assign is_cond_o = (flow_o == FLOW_BR_EQ)  || (flow_o == FLOW_BR_NE) ||
                      (flow_o == FLOW_BR_LEZ) || (flow_o == FLOW_BR_GTZ);
   assign is_link_o = (flow_o == FLOW_CALL)   || (flow_o == FLOW_RCALL);

   // register jumps only come from the special opcode space
   always_comb begin
      if ((flow_o == FLOW_RJUMP) || (flow_o == FLOW_RCALL))
         assert_rjump_special_R6 : assert (opcode_i == OPC_SPECIAL)
            else $error("register jump decoded from a non-special opcode");
      if (is_cond_o)
         assert_cond_not_link_R7 : assert (!is_link_o)
            else $error("conditional branch flagged as a call");
   end

endmodule

// File: rtl/npc_cond.sv
module npc_cond
   import npc_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter bit ZERO_BY_SIGN  = 1'b1,
   parameter bit EQ_BY_XOR     = 1'b1
)(
   input  flow_e            flow_i,
   input  logic [XLEN-1:0]  rs_i,
   input  logic [XLEN-1:0]  rt_i,
   output logic             taken_o
);

   logic ops_equal;
   logic rs_le_zero;

   generate
      if (EQ_BY_XOR) begin : g_eq_xor
         assign ops_equal = ~|(rs_i ^ rt_i);
      end else begin : g_eq_cmp
         assign ops_equal = (rs_i == rt_i);
      end

      if (ZERO_BY_SIGN) begin : g_zero_sign
         assign rs_le_zero = rs_i[XLEN-1] | ~|rs_i;
      end else begin : g_zero_cmp
         assign rs_le_zero = ($signed(rs_i) <= $signed({XLEN{1'b0}}));
      end
   endgenerate

   always_comb begin
      unique case (flow_i)
         FLOW_BR_EQ  : taken_o = ops_equal;
         FLOW_BR_NE  : taken_o = ~ops_equal;
         FLOW_BR_LEZ : taken_o = rs_le_zero;
         FLOW_BR_GTZ : taken_o = ~rs_le_zero;
         FLOW_JUMP, FLOW_CALL, FLOW_RJUMP, FLOW_RCALL : taken_o = 1'b1;
         default     : taken_o = 1'b0;
      endcase
   end

   // a negative operand can never satisfy the strictly-positive branch
   always_comb begin
      if ((flow_i == FLOW_BR_GTZ) && rs_i[XLEN-1])
         assert_gtz_negative_R3 : assert (!taken_o)
            else $error("positive branch taken on a negative operand");
      if (flow_i == FLOW_SEQ)
         assert_seq_not_taken_R1 : assert (!taken_o)
            else $error("sequential flow reported as taken");
   end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN       = 32,
   parameter int IMM_W      = 16,
   parameter int JIDX_W     = 26,
   parameter int INSN_BYTES = 4
)(
   input  logic [XLEN-1:0]   pc_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [JIDX_W-1:0] jidx_i,
   output logic [XLEN-1:0]   seq_pc_o,
   output logic [XLEN-1:0]   br_pc_o,
   output logic [XLEN-1:0]   jmp_pc_o
);

   localparam int ALIGN_SH = $clog2(INSN_BYTES);
   localparam int REGION_W = JIDX_W + ALIGN_SH;
   localparam logic [XLEN-1:0] ONE       = {{(XLEN-1){1'b0}}, 1'b1};
   localparam logic [XLEN-1:0] STEP      = ONE << ALIGN_SH;
   localparam logic [XLEN-1:0] LOW_MASK  = (ONE << REGION_W) - ONE;

   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] region_off;

   assign seq_pc_o   = pc_i + STEP;
   assign disp       = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i} << ALIGN_SH;
   assign br_pc_o    = seq_pc_o + disp;
   assign region_off = {{(XLEN-JIDX_W){1'b0}}, jidx_i} << ALIGN_SH;
   assign jmp_pc_o   = (pc_i & ~LOW_MASK) | region_off;

   // aligned PC in, aligned targets out
   always_comb begin
      if (pc_i[ALIGN_SH-1:0] == '0) begin
         assert_branch_aligned_R4 : assert (br_pc_o[ALIGN_SH-1:0] == '0)
            else $error("branch target lost alignment");
         assert_jump_aligned_R5 : assert (jmp_pc_o[ALIGN_SH-1:0] == '0)
            else $error("jump target lost alignment");
      end
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter int IMM_W         = 16,
   parameter int JIDX_W        = 26,
   parameter int INSN_BYTES    = 4,
   parameter int REG_AW        = 5,
   parameter int LINK_REG      = 31,
   parameter bit ZERO_BY_SIGN  = 1'b1,
   parameter bit EQ_BY_XOR     = 1'b1
)(
   input  logic [XLEN-1:0]   pc_i,
   input  logic [OP_W-1:0]   opcode_i,
   input  logic [FN_W-1:0]   funct_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [JIDX_W-1:0] jidx_i,
   input  logic [XLEN-1:0]   rs_val_i,
   input  logic [XLEN-1:0]   rt_val_i,
   output logic [XLEN-1:0]   next_pc_o,
   output logic              redirect_o,
   output logic              link_we_o,
   output logic [REG_AW-1:0] link_addr_o,
   output logic [XLEN-1:0]   link_val_o
);

   localparam int ALIGN_SH = $clog2(INSN_BYTES);

   generate
      if (INSN_BYTES < 2 || (1 << ALIGN_SH) != INSN_BYTES) begin : g_bad_step
         $error("INSN_BYTES must be a power of two of at least 2");
      end
      if (JIDX_W + ALIGN_SH >= XLEN) begin : g_bad_jidx
         $error("jump index plus alignment must leave upper PC bits");
      end
      if (IMM_W >= XLEN) begin : g_bad_imm
         $error("immediate must be narrower than the PC");
      end
      if (LINK_REG >= (1 << REG_AW)) begin : g_bad_link
         $error("link register number does not fit REG_AW");
      end
   endgenerate

   flow_e           flow;
   logic            is_cond;
   logic            is_link;
   logic            taken;
   logic [XLEN-1:0] seq_pc;
   logic [XLEN-1:0] br_pc;
   logic [XLEN-1:0] jmp_pc;

   npc_decode u_decode (
      .opcode_i  (opcode_i),
      .funct_i   (funct_i),
      .flow_o    (flow),
      .is_cond_o (is_cond),
      .is_link_o (is_link)
   );

   npc_cond #(
      .XLEN         (XLEN),
      .ZERO_BY_SIGN (ZERO_BY_SIGN),
      .EQ_BY_XOR    (EQ_BY_XOR)
   ) u_cond (
      .flow_i  (flow),
      .rs_i    (rs_val_i),
      .rt_i    (rt_val_i),
      .taken_o (taken)
   );

   npc_target #(
      .XLEN       (XLEN),
      .IMM_W      (IMM_W),
      .JIDX_W     (JIDX_W),
      .INSN_BYTES (INSN_BYTES)
   ) u_target (
      .pc_i     (pc_i),
      .imm_i    (imm_i),
      .jidx_i   (jidx_i),
      .seq_pc_o (seq_pc),
      .br_pc_o  (br_pc),
      .jmp_pc_o (jmp_pc)
   );

   always_comb begin
      next_pc_o = seq_pc;
      unique case (flow)
         FLOW_BR_EQ, FLOW_BR_NE, FLOW_BR_LEZ, FLOW_BR_GTZ :
            next_pc_o = taken ? br_pc : seq_pc;
         FLOW_JUMP, FLOW_CALL   : next_pc_o = jmp_pc;
         FLOW_RJUMP, FLOW_RCALL : next_pc_o = rs_val_i;
         default                : next_pc_o = seq_pc;
      endcase
   end

   assign redirect_o  = taken;
   assign link_we_o   = is_link;
   assign link_addr_o = REG_AW'(LINK_REG);
   assign link_val_o  = seq_pc;

   always_comb begin
      if (!redirect_o)
         assert_no_redirect_seq_R1 : assert (next_pc_o == link_val_o)
            else $error("no redirect but next PC is not sequential");
      if (link_we_o)
         assert_link_redirects_R7 : assert (redirect_o)
            else $error("link write without a redirect");
      if (is_cond)
         assert_branch_no_link_R7 : assert (!link_we_o)
            else $error("branch raised the link write");
      if ((flow == FLOW_JUMP) || (flow == FLOW_CALL))
         assert_jump_region_R5 : assert (next_pc_o[XLEN-1:JIDX_W+ALIGN_SH] ==
                                         pc_i[XLEN-1:JIDX_W+ALIGN_SH])
            else $error("jump left the current PC region");
   end

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

   typedef struct packed {
      logic [31:0] pc;
      logic [5:0]  op;
      logic [5:0]  fn;
      logic [15:0] imm;
      logic [25:0] jf;
      logic [31:0] rs;
      logic [31:0] rt;
      logic [31:0] exp_pc;
      logic        exp_redir;
      logic        exp_we;
   } vec_t;

   localparam int N_VEC = 22;
   // requirement tag per row: R1 R2 R2 R2 R2 R3 R3 R3 R3 R3 R3 R3 R5 R5/R7 R6 R6/R7 R9 R4 R4 R1 R1 R9
   localparam vec_t VEC [N_VEC] = '{
      '{32'h0000_1000, 6'h00, 6'h20, 16'h0000, 26'h0, 32'h1, 32'h2, 32'h0000_1004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h04, 6'h00, 16'h0010, 26'h0, 32'h5, 32'h5, 32'h0000_1044, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h04, 6'h00, 16'h0010, 26'h0, 32'h5, 32'h6, 32'h0000_1004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h05, 6'h00, 16'hFFFF, 26'h0, 32'h5, 32'h6, 32'h0000_1000, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h05, 6'h00, 16'hFFFF, 26'h0, 32'h5, 32'h5, 32'h0000_1004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h06, 6'h00, 16'h0002, 26'h0, 32'h0, 32'h0, 32'h0000_100C, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h06, 6'h00, 16'h0002, 26'h0, 32'h8000_0000, 32'h0, 32'h0000_100C, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h06, 6'h00, 16'h0002, 26'h0, 32'h1, 32'h0, 32'h0000_1004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h07, 6'h00, 16'h0002, 26'h0, 32'h1, 32'h0, 32'h0000_100C, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h07, 6'h00, 16'h0002, 26'h0, 32'h0, 32'h0, 32'h0000_1004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h07, 6'h00, 16'h0002, 26'h0, 32'h7FFF_FFFF, 32'h0, 32'h0000_100C, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h07, 6'h00, 16'h0002, 26'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_1004, 1'b0, 1'b0},
      '{32'hA000_0100, 6'h02, 6'h00, 16'h0000, 26'h3FF_FFFF, 32'h0, 32'h0, 32'hAFFF_FFFC, 1'b1, 1'b0},
      '{32'h5000_0000, 6'h03, 6'h00, 16'h0000, 26'h000_0010, 32'h0, 32'h0, 32'h5000_0040, 1'b1, 1'b1},
      '{32'h0000_1000, 6'h00, 6'h08, 16'h0000, 26'h0, 32'h0040_0000, 32'h0, 32'h0040_0000, 1'b1, 1'b0},
      '{32'h0000_1000, 6'h00, 6'h09, 16'h0000, 26'h0, 32'h1234_5678, 32'h0, 32'h1234_5678, 1'b1, 1'b1},
      '{32'h0000_1000, 6'h04, 6'h09, 16'h0001, 26'h0, 32'h7, 32'h7, 32'h0000_1008, 1'b1, 1'b0},
      '{32'hFFFF_FFF8, 6'h04, 6'h00, 16'h0001, 26'h0, 32'h3, 32'h3, 32'h0000_0000, 1'b1, 1'b0},
      '{32'h0002_0000, 6'h04, 6'h00, 16'h8000, 26'h0, 32'h3, 32'h3, 32'h0000_0004, 1'b1, 1'b0},
      '{32'h0000_2000, 6'h0F, 6'h08, 16'h1234, 26'h1, 32'hDEAD_0000, 32'h0, 32'h0000_2004, 1'b0, 1'b0},
      '{32'h0000_2000, 6'h23, 6'h09, 16'h0004, 26'h5, 32'h0000_3000, 32'h0, 32'h0000_2004, 1'b0, 1'b0},
      '{32'h0000_1000, 6'h06, 6'h00, 16'h0002, 26'h0, 32'h0, 32'hFFFF_FFFF, 32'h0000_100C, 1'b1, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_i = '0;
   logic [5:0]  opcode_i = '0;
   logic [5:0]  funct_i = '0;
   logic [15:0] imm_i = '0;
   logic [25:0] jidx_i = '0;
   logic [31:0] rs_val_i = '0;
   logic [31:0] rt_val_i = '0;
   logic [31:0] next_pc_o;
   logic        redirect_o;
   logic        link_we_o;
   logic [4:0]  link_addr_o;
   logic [31:0] link_val_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   npc_unit uut (
      .pc_i        (pc_i),
      .opcode_i    (opcode_i),
      .funct_i     (funct_i),
      .imm_i       (imm_i),
      .jidx_i      (jidx_i),
      .rs_val_i    (rs_val_i),
      .rt_val_i    (rt_val_i),
      .next_pc_o   (next_pc_o),
      .redirect_o  (redirect_o),
      .link_we_o   (link_we_o),
      .link_addr_o (link_addr_o),
      .link_val_o  (link_val_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      @(negedge clk);
      pc_i = v.pc; opcode_i = v.op; funct_i = v.fn; imm_i = v.imm;
      jidx_i = v.jf; rs_val_i = v.rs; rt_val_i = v.rt;
      #5;
   endtask

   task automatic check_vec(input string req, input vec_t v);
      drive(v);
      chk({req, " next_pc"}, next_pc_o, v.exp_pc);
      chk("R8 redirect", {31'd0, redirect_o}, {31'd0, v.exp_redir});
      chk("R7 link_we", {31'd0, link_we_o}, {31'd0, v.exp_we});
      chk("R7 link_val", link_val_o, v.pc + 32'd4);
      chk("R7 link_addr", {27'd0, link_addr_o}, 32'd31);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      // reset state: all-zero instruction word is a plain sequential op (R1)
      repeat (2) @(negedge clk);
      #5;
      chk("R1 reset next_pc", next_pc_o, 32'h0000_0004);
      chk("R1 reset link_we", {31'd0, link_we_o}, 32'd0);
      chk("R8 reset redirect", {31'd0, redirect_o}, 32'd0);
      rst = 1'b0;

      for (int i = 0; i < N_VEC; i++) begin
         check_vec($sformatf("vec%0d R1/R2/R3/R4/R5/R6/R9", i), VEC[i]);
      end

      // R8/R7: register call whose target equals the sequential address
      check_vec("R6 jalr to pc+4",
         '{32'h0000_4000, 6'h00, 6'h09, 16'h0, 26'h0, 32'h0000_4004, 32'h0,
           32'h0000_4004, 1'b1, 1'b1});
      // R8: taken branch with zero displacement still redirects
      check_vec("R4 zero displacement",
         '{32'h0000_4000, 6'h05, 6'h00, 16'h0, 26'h0, 32'h1, 32'h2,
           32'h0000_4004, 1'b1, 1'b0});
      // R5: uses current PC's region even at the region's last word
      check_vec("R5 region edge",
         '{32'h3FFF_FFFC, 6'h03, 6'h00, 16'h0, 26'h000_0001, 32'h0, 32'h0,
           32'h3000_0004, 1'b1, 1'b1});
      // R9: jr funct under a jump opcode behaves as the jump
      check_vec("R9 funct ignored on j",
         '{32'h0000_1000, 6'h02, 6'h08, 16'h0, 26'h000_0100, 32'h9999_0000, 32'h0,
           32'h0000_0400, 1'b1, 1'b0});
      // R9: second operand varied on bgtz leaves result unchanged
      check_vec("R9 rt ignored on bgtz",
         '{32'h0000_1000, 6'h07, 6'h00, 16'h0002, 26'h0, 32'h0, 32'h0000_0005,
           32'h0000_1004, 1'b0, 1'b0});
      // R2: equality across all bits, differing only in bit 31
      check_vec("R2 msb differs",
         '{32'h0000_1000, 6'h04, 6'h00, 16'h0010, 26'h0, 32'h8000_0001, 32'h0000_0001,
           32'h0000_1004, 1'b0, 1'b0});

      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule